// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block is a write-only, three-pin configuration port. It has a serial clock pin, a serial data pin and a latch pin. All three pins are asynchronous to the chip. They are oversampled in a fast system clock domain through two-flop synchronizers, and their edges are found there.

Each detected rising edge of the serial clock shifts the synchronized data bit into a 32-bit word, most-significant bit first. A rising edge of the latch pin commits that word. The low four bits of the word are an address. The address picks one of eight per-channel control registers, or the global control register. The channel registers drive divider, delay, source-select and enable fields in parallel. The global register drives a power-down flag.

The system clock must run at least four times faster than the serial clock.

Top module: `serial_cfg_regs`

## Requirements
- R1: After reset every channel field (enable, mux, divide, delay) and the power-down flag read zero, so every channel is disabled.
- R2: Bits are taken on serial clock rising edges, most-significant first, so the first bit shifted becomes word bit 31 and the last becomes bit 0.
- R3: Output registers change only on a latch rising edge. Shifting with the latch low, or holding the latch high, leaves them unchanged. A latch pulse with no new serial clocks commits the word already shifted.
- R4: Word bits [3:0] in 0..7 select that channel. The channel takes enable = bit 4, mux = bits [6:5], divide = bits [14:7] and delay = bits [18:15]. All other registers keep their values.
- R5: Address 14 writes the global register: power-down = bit 4. Channel registers are unchanged.
- R6: A commit to addresses 8 to 13 or 15 changes no output.
- R7: When more than 32 bits are clocked in before a latch, only the last 32 count.
- R8: A second write to the same channel replaces all of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock pin (asynchronous) |
| serData | input | 1 | Serial data pin (asynchronous) |
| serLatch | input | 1 | Latch pin; a rising edge commits the word |
| chEnable | output | 8 | Per-channel enable, bit n for channel n |
| chMux | output | 16 | Per-channel source select, 2 bits per channel |
| chDivide | output | 64 | Per-channel divide value, 8 bits per channel |
| chDelay | output | 32 | Per-channel delay value, 4 bits per channel |
| powerDown | output | 1 | Global power-down flag |

## Verification
The assertions assume the pins respect the serial timing:

- the serial clock and the latch never rise within the same system clock period;
- every pin level lasts at least two system clocks;
- data is steady around each serial clock rise.

Under those assumptions, at most one strobe fires per cycle, and the address visible at a commit is the one the data path uses. The stimulus keeps within these assumptions by using a 10 ns system clock and an 80 ns serial period. Data changes only while the serial clock is low. The latch rises and falls at least 40 ns away from any serial clock edge.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  parameter int WORD_W      = 32;
  parameter int ADDR_W      = 4;
  parameter int GLOBAL_ADDR = 14;
  parameter int SYNC_STAGES = 2;

  // strobes from the control to the data path, one cycle wide each
  typedef struct packed {
    logic shiftEn;
    logic commit;
  } cfgStrobes_t;
endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/serial_cfg_ctrl.sv
module serial_cfg_ctrl
  import serial_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLatch,
  output cfgStrobes_t strobes,
  output logic        dataBit
);
  logic [2:0] pinSync;
  logic       clkPrev;
  logic       latchPrev;

  serial_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serLatch, serData, serClk}),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      clkPrev   <= pinSync[0];
      latchPrev <= pinSync[2];
    end
  end

  always_comb begin
    strobes.shiftEn = pinSync[0] & ~clkPrev;
    strobes.commit  = pinSync[2] & ~latchPrev;
  end

  assign dataBit = pinSync[1];
endmodule

// File: rtl/serial_cfg_dp.sv
module serial_cfg_dp
  import serial_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MUX_W  = 2,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgStrobes_t             strobes,
  input  logic                    dataBit,
  output logic [WORD_W-1:0]       shiftWord,
  output logic [NUM_CH-1:0]       chEnable,
  output logic [NUM_CH*MUX_W-1:0] chMux,
  output logic [NUM_CH*DIV_W-1:0] chDivide,
  output logic [NUM_CH*DLY_W-1:0] chDelay,
  output logic                    powerDown
);
  localparam int EN_POS  = ADDR_W;
  localparam int MUX_LSB = EN_POS + 1;
  localparam int DIV_LSB = MUX_LSB + MUX_W;
  localparam int DLY_LSB = DIV_LSB + DIV_W;
  localparam int PD_POS  = ADDR_W;

  logic [ADDR_W-1:0] addr;
  assign addr = shiftWord[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftWord <= '0;
    else if (strobes.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], dataBit};
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chEnable[g]               <= 1'b0;
        chMux[g*MUX_W +: MUX_W]   <= '0;
        chDivide[g*DIV_W +: DIV_W] <= '0;
        chDelay[g*DLY_W +: DLY_W] <= '0;
      end else if (strobes.commit && addr == ADDR_W'(g)) begin
        chEnable[g]               <= shiftWord[EN_POS];
        chMux[g*MUX_W +: MUX_W]   <= shiftWord[MUX_LSB +: MUX_W];
        chDivide[g*DIV_W +: DIV_W] <= shiftWord[DIV_LSB +: DIV_W];
        chDelay[g*DLY_W +: DLY_W] <= shiftWord[DLY_LSB +: DLY_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                           powerDown <= 1'b0;
    else if (strobes.commit && addr == ADDR_W'(GLOBAL_ADDR)) powerDown <= shiftWord[PD_POS];
  end
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
  import serial_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MUX_W  = 2,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    serClk,
  input  logic                    serData,
  input  logic                    serLatch,
  output logic [NUM_CH-1:0]       chEnable,
  output logic [NUM_CH*MUX_W-1:0] chMux,
  output logic [NUM_CH*DIV_W-1:0] chDivide,
  output logic [NUM_CH*DLY_W-1:0] chDelay,
  output logic                    powerDown
);
  cfgStrobes_t       strobes;
  logic              dataBit;
  logic [WORD_W-1:0] shiftWord;

  serial_cfg_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serData  (serData),
    .serLatch (serLatch),
    .strobes  (strobes),
    .dataBit  (dataBit)
  );

  serial_cfg_dp #(
    .NUM_CH(NUM_CH), .MUX_W(MUX_W), .DIV_W(DIV_W), .DLY_W(DLY_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataBit   (dataBit),
    .shiftWord (shiftWord),
    .chEnable  (chEnable),
    .chMux     (chMux),
    .chDivide  (chDivide),
    .chDelay   (chDelay),
    .powerDown (powerDown)
  );
endmodule

// File: rtl/serial_cfg_chk.sv
module serial_cfg_chk
  import serial_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MUX_W  = 2,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input cfgStrobes_t             strobes,
  input logic [WORD_W-1:0]       shiftWord,
  input logic [NUM_CH-1:0]       chEnable,
  input logic [NUM_CH*MUX_W-1:0] chMux,
  input logic [NUM_CH*DIV_W-1:0] chDivide,
  input logic [NUM_CH*DLY_W-1:0] chDelay,
  input logic                    powerDown
);
  logic [ADDR_W-1:0] addr;
  logic              undefAddr;
  assign addr      = shiftWord[ADDR_W-1:0];
  assign undefAddr = (int'(addr) >= NUM_CH) && (int'(addr) != GLOBAL_ADDR);

  // R2 / R3: with pins inside their timing, shift and commit never coincide
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.shiftEn, strobes.commit}));

  // R3: no commit strobe means no output moves
  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable({chEnable, chMux, chDivide, chDelay, powerDown}));

  // R4: a channel write leaves the global register alone
  a_r4_channel_keeps_global: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && int'(addr) < NUM_CH) |=> $stable(powerDown));

  // R5: a global write leaves every channel alone
  a_r5_global_keeps_channels: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && int'(addr) == GLOBAL_ADDR) |=> $stable({chEnable, chMux, chDivide, chDelay}));

  // R6: undefined addresses change nothing
  a_r6_undefined_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && undefAddr) |=> $stable({chEnable, chMux, chDivide, chDelay, powerDown}));
endmodule

bind serial_cfg_regs serial_cfg_chk #(
  .NUM_CH(NUM_CH), .MUX_W(MUX_W), .DIV_W(DIV_W), .DLY_W(DLY_W)
) chk_i (.*);

// File: tb/serial_cfg_regs_tb.sv
module serial_cfg_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SER_HALF   = 40;
  localparam int NCH        = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic [NCH-1:0]   chEnable;
  logic [NCH*2-1:0] chMux;
  logic [NCH*8-1:0] chDivide;
  logic [NCH*4-1:0] chDelay;
  logic             powerDown;

  int checks = 0, fails = 0;
  bit done = 0;

  logic       expEn  [NCH];
  logic [1:0] expMux [NCH];
  logic [7:0] expDiv [NCH];
  logic [3:0] expDly [NCH];
  logic       expPd;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_regs dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLatch(serLatch),
    .chEnable(chEnable), .chMux(chMux), .chDivide(chDivide), .chDelay(chDelay),
    .powerDown(powerDown)
  );

  // word layout from R4: addr [3:0], enable 4, mux [6:5], divide [14:7], delay [18:15]
  function automatic logic [31:0] mkChan(int a, logic en, logic [1:0] mx, logic [7:0] dv, logic [3:0] dl);
    logic [31:0] w = '0;
    w[3:0] = 4'(a); w[4] = en; w[6:5] = mx; w[14:7] = dv; w[18:15] = dl;
    w[31:19] = 13'h1abc;
    return w;
  endfunction

  // expected-state update from R4 / R5 / R6
  task automatic modelCommit(logic [31:0] w);
    int a = int'(w[3:0]);
    if (a < NCH) begin
      expEn[a] = w[4]; expMux[a] = w[6:5]; expDiv[a] = w[14:7]; expDly[a] = w[18:15];
    end else if (a == 14) expPd = w[4];
  endtask

  task automatic checkAll(string tag);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      logic [14:0] got, exp;
      got = {chEnable[c], chMux[c*2 +: 2], chDivide[c*8 +: 8], chDelay[c*4 +: 4]};
      exp = {expEn[c], expMux[c], expDiv[c], expDly[c]};
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s ch%0d got %h exp %h", tag, c, got, exp);
      end
    end
    checks++;
    if (powerDown !== expPd) begin
      fails++;
      $display("FAIL %s powerDown got %b exp %b", tag, powerDown, expPd);
    end
  endtask

  task automatic shiftBits(logic [63:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      #(SER_HALF) serClk = 1'b1;
      #(SER_HALF) serClk = 1'b0;
    end
    #(SER_HALF);
  endtask

  task automatic pulseLatch();
    serLatch = 1'b1;
    #(SER_HALF * 2) serLatch = 1'b0;
    #(SER_HALF * 2);
  endtask

  task automatic writeWord(logic [31:0] w);
    shiftBits({32'h0, w}, 32);
    pulseLatch();
    modelCommit(w);
  endtask

  task automatic t_reset();
    checkAll("R1 reset state");
  endtask

  task automatic t_channels();
    writeWord(mkChan(0, 1'b1, 2'd2, 8'hA5, 4'h3));
    checkAll("R2 R4 ch0 write");
    writeWord(mkChan(7, 1'b1, 2'd1, 8'h3C, 4'hF));
    checkAll("R4 ch7 write");
    writeWord(mkChan(3, 1'b0, 2'd3, 8'h81, 4'h9));
    checkAll("R2 R4 ch3 write");
  endtask

  task automatic t_global();
    logic [31:0] w = 32'hFFFF_FFE0 | 32'h1E;
    writeWord(w);
    checkAll("R5 global set");
    writeWord(32'h0000_000E);
    checkAll("R5 global clear");
    writeWord(w);
  endtask

  task automatic t_undefined();
    writeWord(32'hFFFF_FFF8);
    checkAll("R6 addr 8 ignored");
    writeWord(32'hFFFF_FFFD);
    checkAll("R6 addr 13 ignored");
    writeWord(32'hFFFF_FFFF);
    checkAll("R6 addr 15 ignored");
  endtask

  task automatic t_latchOnly();
    logic [31:0] w = mkChan(5, 1'b1, 2'd3, 8'h5A, 4'h6);
    shiftBits({32'h0, w}, 32);
    checkAll("R3 no latch no change");
    serLatch = 1'b1;
    #(SER_HALF * 2);
    modelCommit(w);
    checkAll("R3 latch commits shifted word");
    shiftBits({32'h0, mkChan(5, 1'b0, 2'd0, 8'h11, 4'h1)}, 32);
    checkAll("R3 latch held high no commit");
    serLatch = 1'b0;
    #(SER_HALF * 2);
    pulseLatch();
    modelCommit(mkChan(5, 1'b0, 2'd0, 8'h11, 4'h1));
    checkAll("R3 fresh latch pulse commits");
  endtask

  task automatic t_longFrame();
    logic [31:0] w = mkChan(2, 1'b1, 2'd1, 8'hC3, 4'hA);
    shiftBits({24'h0, 8'hF6, w}, 40);
    pulseLatch();
    modelCommit(w);
    checkAll("R7 last 32 bits kept");
  endtask

  task automatic t_overwrite();
    writeWord(mkChan(7, 1'b0, 2'd2, 8'h02, 4'h4));
    checkAll("R8 ch7 overwrite");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      expEn[c] = 0; expMux[c] = 0; expDiv[c] = 0; expDly[c] = 0;
    end
    expPd = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_channels();
    t_global();
    t_undefined();
    t_latchOnly();
    t_longFrame();
    t_overwrite();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired got hung exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule